// File: doc/BRIEF.md
# Dual-Mode Serial Transceiver

This block is a serial transmitter and receiver that runs either in character-framed asynchronous mode or in clocked synchronous mode. A parallel side accepts a byte to send and presents a received byte with status flags. A serial side has one data output, one data input and a serial clock. The clock pin is split into an input, an output and an output enable, so that a pad can form the bidirectional pin. A built-in programmable divider acts as the bit-rate generator.

In asynchronous mode a character has a low start bit, then 7 or 8 data bits sent LSB first, then an optional parity bit and an optional multiprocessor address bit, then one or two high stop bits. The receiver reports parity, framing, overrun and break conditions. In synchronous mode exactly eight bits are moved per transfer. Data changes after a falling clock edge and is sampled on the rising edge. The clock comes either from the internal divider, driven out on the clock pin, or from the clock pin itself.

The clock-source field `clk_sel` is read together with `sync_mode`. Bit 1 set selects the external clock on `sck_i`. Bit 1 clear selects the internal divider. In asynchronous mode, bit 0 then turns on a bit-rate clock output.

Top module: `duo_serial`

## Requirements
- R1: `sync_mode`=0 selects asynchronous framing and `sync_mode`=1 selects synchronous transfer of exactly 8 bits per character.
- R2: An asynchronous transmit frame is a 0 start bit, then the data LSB first (7 bits when `len7`=1, otherwise 8), then parity if `par_en`, then the address bit `tx_mpb` if `mp_en`, then 1 stop bit, or 2 when `two_stop`=1. `txd` rests at 1 when idle.
- R3: The parity bit makes the count of ones over data and parity even (`par_odd`=0) or odd (`par_odd`=1). The received address bit is presented on `rx_mpb`, and `rx_data` bit 7 reads 0 for 7-bit characters.
- R4: A received parity mismatch sets `rx_par_err`. A 0 in the first stop position sets `rx_frame_err`.
- R5: A frame that is 0 in every position through the first stop bit sets `rx_break` and `rx_frame_err`. The receiver starts no new character until the line has returned to 1.
- R6: When a character completes while `rx_full` is 1, `rx_overrun` is set and `rx_data` keeps the unread byte. A one-cycle `rx_read` clears `rx_full` and all four error flags.
- R7: With the internal clock in asynchronous mode, one bit lasts 16*(`brg_div`+1) clock cycles. `clk_sel`=01 drives `sck_o` at the bit rate with `sck_oe`=1.
- R8: With `clk_sel`=1x in asynchronous mode, each rising edge of `sck_i` is one sixteenth of a bit, and `sck_oe` is 0.
- R9: In synchronous mode with the internal clock, a transfer emits 8 low pulses on `sck_o` of half-period `brg_div`+1 cycles, and `sck_oe` is 1. `sck_o` rests at 1 between transfers.
- R10: In synchronous mode, `len7`, `par_en` and `mp_en` have no effect and only overrun is reported. With `clk_sel`=1x, `txd` advances after each falling `sck_i` edge and `rxd` is sampled on each rising edge.
- R11: After reset `txd`=1, `tx_busy`=0, `rx_full`=0, all error flags are 0 and `sck_oe`=0 for `clk_sel`=00 in asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 0 asynchronous, 1 clocked synchronous |
| clk_sel | input | 2 | Clock source: bit 1 external, bit 0 clock output in async |
| len7 | input | 1 | Asynchronous 7-bit characters |
| par_en | input | 1 | Asynchronous parity enable |
| par_odd | input | 1 | Odd parity when 1 |
| mp_en | input | 1 | Asynchronous address bit enable |
| two_stop | input | 1 | Two stop bits when 1 |
| brg_div | input | DIV_W | Bit-rate divider value |
| tx_data | input | 8 | Byte to send |
| tx_mpb | input | 1 | Address bit to send |
| tx_load | input | 1 | One-cycle start of a transmission |
| tx_busy | output | 1 | Transmission in progress |
| rx_data | output | 8 | Received byte |
| rx_mpb | output | 1 | Received address bit |
| rx_full | output | 1 | Unread character present |
| rx_read | input | 1 | One-cycle acknowledge of the received character |
| rx_frame_err | output | 1 | Stop position was 0 |
| rx_par_err | output | 1 | Parity mismatch |
| rx_overrun | output | 1 | Character lost while full |
| rx_break | output | 1 | All-zero frame seen |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| sck_i | input | 1 | Serial clock from the pin |
| sck_o | output | 1 | Serial clock to the pin |
| sck_oe | output | 1 | Drive enable for the clock pin |

## Verification
Asynchronous loopback is run with three formats: 8 bits with no parity, 7 bits with even parity and two stops, and 8 bits with odd parity and an address bit. This shows that the transmitter and receiver agree on field positions, and the 0xFF byte in 7-bit mode exposes a missing mask. Frames driven bit by bit supply a wrong parity bit, a 0 stop bit with nonzero data, and an all-zero line that is held low longer than a frame. These tell parity, framing and break apart, and show that a long break yields one character only. Bit widths are measured on a 0x01 byte under the internal and the external clock, which separates the x16 subsampling paths. Synchronous transfers are clocked internally in loopback and externally by the bench with unequal transmit and receive bytes, which exposes swapped edges or bit orders.

// File: rtl/duo_serial_pkg.sv
package duo_serial_pkg;

    localparam int FRAME_W = 13;   // start + 8 data + parity + addr + 2 stop
    localparam int CAP_W   = 12;   // receiver capture: data, parity, addr, stop

    typedef struct packed {
        logic sync;
        logic len7;
        logic par_en;
        logic par_odd;
        logic mp_en;
        logic two_stop;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [3:0]         nbits;
    } frame_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_BITS, RX_DONE, RX_WAIT_HI
    } rx_state_e;

    // parity bit value for the data that is actually sent
    function automatic logic par_of(input logic [7:0] d, input logic len7, input logic odd);
        logic [7:0] m;
        m = len7 ? {1'b0, d[6:0]} : d;
        return (^m) ^ odd;
    endfunction

    function automatic frame_t build_frame(input fmt_t f, input logic [7:0] d, input logic mpb);
        frame_t     fr;
        logic [3:0] pos;
        fr.bits    = '1;
        fr.bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (!(f.len7 && i == 7)) fr.bits[i+1] = d[i];
        end
        pos = f.len7 ? 4'd8 : 4'd9;
        if (f.par_en) begin
            fr.bits[pos] = par_of(d, f.len7, f.par_odd);
            pos = pos + 4'd1;
        end
        if (f.mp_en) begin
            fr.bits[pos] = mpb;
            pos = pos + 4'd1;
        end
        fr.nbits = pos + (f.two_stop ? 4'd2 : 4'd1);
        return fr;
    endfunction

endpackage

// File: rtl/duo_serial_brg.sv
module duo_serial_brg #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             bit_clk
);
    localparam int SUBS = 16;
    localparam int PH_W = $clog2(SUBS);

    logic [DIV_W-1:0] cnt;
    logic [PH_W-1:0]  phase;

    assign tick    = (cnt == '0) && !hold;
    assign bit_clk = phase[PH_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= div;
            phase <= '0;
        end else if (hold) begin
            cnt <= div;
        end else if (cnt == '0) begin
            cnt   <= div;
            phase <= phase + 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/duo_serial_tx.sv
module duo_serial_tx
    import duo_serial_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fmt_t       fmt,
    input  logic       tick16,
    input  logic       s_rise,
    input  logic       s_fall,
    input  logic       load,
    input  logic [7:0] data,
    input  logic       mpb,
    output logic       txd,
    output logic       busy
);
    logic [FRAME_W-1:0] sh;
    logic [3:0]         left;
    logic [3:0]         sub;
    frame_t             fr;

    assign fr  = build_frame(fmt, data, mpb);
    assign txd = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
            sub  <= '0;
        end else if (!busy) begin
            if (load) begin
                busy <= 1'b1;
                sub  <= '0;
                if (fmt.sync) begin
                    sh   <= {{(FRAME_W-8){1'b1}}, data};
                    left <= 4'd8;
                end else begin
                    sh   <= fr.bits;
                    left <= fr.nbits;
                end
            end
        end else if (fmt.sync) begin
            if (s_rise) begin
                left <= left - 4'd1;
                if (left == 4'd1) busy <= 1'b0;
            end else if (s_fall && left != 4'd8) begin
                sh <= {1'b1, sh[FRAME_W-1:1]};
            end
        end else if (tick16) begin
            sub <= sub + 4'd1;
            if (sub == 4'd15) begin
                sh   <= {1'b1, sh[FRAME_W-1:1]};
                left <= left - 4'd1;
                if (left == 4'd1) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/duo_serial_rx.sv
module duo_serial_rx
    import duo_serial_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync,
    input  logic       len7,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       mp_en,
    input  logic       tick16,
    input  logic       s_rise,
    input  logic       rxd,
    input  logic       rd,
    output logic [7:0] data,
    output logic       mpb,
    output logic       full,
    output logic       frame_err,
    output logic       par_err,
    output logic       overrun,
    output logic       brk
);
    rx_state_e        st;
    logic [3:0]       sub, idx;
    logic [CAP_W-1:0] cap;
    logic [3:0]       need, lpos, ppos, spos;
    logic [7:0]       dval;
    logic [CAP_W-1:0] mask;

    // positions: parity at lpos, address bit at ppos, first stop at spos
    assign lpos = len7 ? 4'd7 : 4'd8;
    assign ppos = lpos + {3'b0, par_en};
    assign spos = ppos + {3'b0, mp_en};
    assign need = sync ? 4'd8 : spos + 4'd1;
    assign dval = (sync || !len7) ? cap[7:0] : {1'b0, cap[6:0]};
    assign mask = ~({CAP_W{1'b1}} << (spos + 4'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            sub       <= '0;
            idx       <= '0;
            cap       <= '0;
            data      <= '0;
            mpb       <= 1'b0;
            full      <= 1'b0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
            overrun   <= 1'b0;
            brk       <= 1'b0;
        end else begin
            if (rd) begin
                full      <= 1'b0;
                frame_err <= 1'b0;
                par_err   <= 1'b0;
                overrun   <= 1'b0;
                brk       <= 1'b0;
            end
            case (st)
                RX_IDLE: begin
                    if (sync) begin
                        if (s_rise) begin
                            cap[idx] <= rxd;
                            idx      <= idx + 4'd1;
                            if (idx == 4'd7) st <= RX_DONE;
                        end
                    end else if (tick16 && !rxd) begin
                        st  <= RX_START;
                        sub <= '0;
                        idx <= '0;
                    end
                end
                RX_START: if (tick16) begin
                    sub <= sub + 4'd1;
                    if (sub == 4'd6) begin
                        sub <= '0;
                        st  <= rxd ? RX_IDLE : RX_BITS;
                    end
                end
                RX_BITS: if (tick16) begin
                    sub <= sub + 4'd1;
                    if (sub == 4'd15) begin
                        sub      <= '0;
                        cap[idx] <= rxd;
                        idx      <= idx + 4'd1;
                        if (idx == need - 4'd1) st <= RX_DONE;
                    end
                end
                RX_DONE: begin
                    idx <= '0;
                    st  <= sync ? RX_IDLE : RX_WAIT_HI;
                    if (full) begin
                        overrun <= 1'b1;
                    end else begin
                        data      <= dval;
                        full      <= 1'b1;
                        mpb       <= !sync && mp_en && cap[ppos];
                        frame_err <= !sync && !cap[spos];
                        par_err   <= !sync && par_en && (cap[lpos] != par_of(dval, len7, par_odd));
                        brk       <= !sync && ((cap & mask) == '0);
                    end
                end
                RX_WAIT_HI: if (rxd) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/duo_serial.sv
module duo_serial
    import duo_serial_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_mode,
    input  logic [1:0]       clk_sel,
    input  logic             len7,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             mp_en,
    input  logic             two_stop,
    input  logic [DIV_W-1:0] brg_div,
    input  logic [7:0]       tx_data,
    input  logic             tx_mpb,
    input  logic             tx_load,
    output logic             tx_busy,
    output logic [7:0]       rx_data,
    output logic             rx_mpb,
    output logic             rx_full,
    input  logic             rx_read,
    output logic             rx_frame_err,
    output logic             rx_par_err,
    output logic             rx_overrun,
    output logic             rx_break,
    output logic             txd,
    input  logic             rxd,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe
);
    fmt_t       fmt;
    logic       ext, int_sync;
    logic [2:0] sck_sy;
    logic [1:0] rxd_sy;
    logic       ext_rise, ext_fall;
    logic       tick, bit_clk;
    logic       sck_int, int_en, int_rise, int_fall;
    logic       tick16, s_rise, s_fall;

    assign fmt = '{sync: sync_mode, len7: len7, par_en: par_en, par_odd: par_odd,
                   mp_en: mp_en, two_stop: two_stop};
    assign ext      = clk_sel[1];
    assign int_sync = sync_mode && !ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sy <= 3'b111;
            rxd_sy <= 2'b11;
        end else begin
            sck_sy <= {sck_sy[1:0], sck_i};
            rxd_sy <= {rxd_sy[0], rxd};
        end
    end

    assign ext_rise = sck_sy[1] && !sck_sy[2];
    assign ext_fall = !sck_sy[1] && sck_sy[2];

    duo_serial_brg #(.DIV_W(DIV_W)) u_brg (
        .clk     (clk),
        .rst     (rst),
        .hold    (sync_mode && !tx_busy),
        .div     (brg_div),
        .tick    (tick),
        .bit_clk (bit_clk)
    );

    // internal synchronous clock: toggles on divider ticks during a transfer
    assign int_en   = int_sync && tx_busy && tick;
    assign int_rise = int_en && !sck_int;
    assign int_fall = int_en && sck_int;

    always_ff @(posedge clk) begin
        if (rst || !int_sync) sck_int <= 1'b1;
        else if (int_en)      sck_int <= !sck_int;
    end

    assign tick16 = ext ? ext_rise : tick;
    assign s_rise = ext ? ext_rise : int_rise;
    assign s_fall = ext ? ext_fall : int_fall;
    assign sck_o  = sync_mode ? sck_int : bit_clk;
    assign sck_oe = !ext && (sync_mode || clk_sel[0]);

    duo_serial_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .fmt    (fmt),
        .tick16 (tick16),
        .s_rise (s_rise),
        .s_fall (s_fall),
        .load   (tx_load),
        .data   (tx_data),
        .mpb    (tx_mpb),
        .txd    (txd),
        .busy   (tx_busy)
    );

    duo_serial_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .sync      (sync_mode),
        .len7      (len7),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .mp_en     (mp_en),
        .tick16    (tick16),
        .s_rise    (s_rise),
        .rxd       (rxd_sy[1]),
        .rd        (rx_read),
        .data      (rx_data),
        .mpb       (rx_mpb),
        .full      (rx_full),
        .frame_err (rx_frame_err),
        .par_err   (rx_par_err),
        .overrun   (rx_overrun),
        .brk       (rx_break)
    );
endmodule

// File: rtl/duo_serial_chk.sv
module duo_serial_chk (
    input logic       clk,
    input logic       rst,
    input logic       sync_mode,
    input logic       ext_clk,
    input logic       tx_busy,
    input logic       txd,
    input logic       rx_full,
    input logic       rx_read,
    input logic [7:0] rx_data,
    input logic       rx_frame_err,
    input logic       rx_par_err,
    input logic       rx_overrun,
    input logic       rx_break,
    input logic       sck_o
);
    // R6
    overrun_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_full));

    // R6
    unread_data_held_chk: assert property (@(posedge clk) disable iff (rst)
        rx_full && !rx_read |=> rx_full && $stable(rx_data));

    // R5
    break_has_frame_err_chk: assert property (@(posedge clk) disable iff (rst)
        rx_break |-> rx_frame_err);

    // R10
    sync_only_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        sync_mode |-> !rx_frame_err && !rx_par_err && !rx_break);

    // R2
    start_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) && !sync_mode |-> !txd);

    // R9
    sck_rests_high_chk: assert property (@(posedge clk) disable iff (rst)
        sync_mode && !ext_clk && !tx_busy |-> sck_o);
endmodule

bind duo_serial duo_serial_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sync_mode    (sync_mode),
    .ext_clk      (clk_sel[1]),
    .tx_busy      (tx_busy),
    .txd          (txd),
    .rx_full      (rx_full),
    .rx_read      (rx_read),
    .rx_data      (rx_data),
    .rx_frame_err (rx_frame_err),
    .rx_par_err   (rx_par_err),
    .rx_overrun   (rx_overrun),
    .rx_break     (rx_break),
    .sck_o        (sck_o)
);

// File: tb/duo_serial_tb.sv
module duo_serial_tb;
    localparam int DIV = 3;
    localparam int BIT = 16 * (DIV + 1);

    typedef struct {
        logic [7:0] d;
        logic [4:0] fl;   // mpb, frame, parity, overrun, break
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_mode = 1'b0, len7 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic mp_en = 1'b0, two_stop = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic [7:0] tx_data = '0;
    logic tx_mpb = 1'b0, tx_load = 1'b0, rx_read = 1'b0;
    logic rxd_drv = 1'b1, sck_drv = 1'b1, loop = 1'b0, ext_run = 1'b0, mon_hold = 1'b0;
    logic tx_busy, rx_mpb, rx_full, rx_frame_err, rx_par_err, rx_overrun, rx_break;
    logic txd, sck_o, sck_oe;
    logic [7:0] rx_data;
    wire  rxd_w = loop ? txd : rxd_drv;

    int   checks = 0, errors = 0;
    exp_t sbq[$];

    always #10 clk = ~clk;

    duo_serial #(.DIV_W(8)) u_dut (
        .clk(clk), .rst(rst), .sync_mode(sync_mode), .clk_sel(clk_sel), .len7(len7),
        .par_en(par_en), .par_odd(par_odd), .mp_en(mp_en), .two_stop(two_stop),
        .brg_div(8'(DIV)), .tx_data(tx_data), .tx_mpb(tx_mpb), .tx_load(tx_load),
        .tx_busy(tx_busy), .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_full(rx_full),
        .rx_read(rx_read), .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err),
        .rx_overrun(rx_overrun), .rx_break(rx_break), .txd(txd), .rxd(rxd_w),
        .sck_i(sck_drv), .sck_o(sck_o), .sck_oe(sck_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic expect_rx(input logic [7:0] d, input logic [4:0] fl, input string tag);
        exp_t e;
        e.d = d; e.fl = fl; e.tag = tag;
        sbq.push_back(e);
    endtask

    // monitor: pops expected characters and acknowledges them
    initial begin
        forever begin
            @(negedge clk);
            rx_read = 1'b0;
            if (rx_full && !mon_hold) begin
                if (sbq.size() == 0) begin
                    chk("scoreboard unexpected char", {24'h0, rx_data}, 32'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(e.tag, {19'h0, rx_data, rx_mpb, rx_frame_err, rx_par_err, rx_overrun, rx_break},
                        {19'h0, e.d, e.fl});
                end
                rx_read = 1'b1;
            end
        end
    end

    // free-running external clock, period 8 system cycles
    initial begin
        int ecnt = 0;
        forever begin
            @(negedge clk);
            if (ext_run) begin
                ecnt++;
                if (ecnt == 4) begin
                    sck_drv = ~sck_drv;
                    ecnt = 0;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    task automatic cfg(input logic sm, input logic [1:0] cs, input logic l7, input logic pe,
                       input logic po, input logic me, input logic ts);
        @(negedge clk);
        rst = 1'b1;
        sync_mode = sm; clk_sel = cs; len7 = l7; par_en = pe;
        par_odd = po; mp_en = me; two_stop = ts;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic tx_send(input logic [7:0] d, input logic m);
        @(negedge clk);
        tx_data = d; tx_mpb = m; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic wait_tx_idle();
        while (tx_busy) @(negedge clk);
        repeat (BIT) @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 40000 && (sbq.size() != 0 || rx_full); i++) @(negedge clk);
    endtask

    // width in cycles of the first high bit after the start bit
    task automatic high_width(output int w);
        w = 0;
        while (txd) @(negedge clk);
        while (!txd) @(negedge clk);
        while (txd) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic rx_bang(input logic [12:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            rxd_drv = bits[i];
            repeat (BIT) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    function automatic logic [12:0] frame8e1(input logic [7:0] d, input logic p, input logic stp);
        return {2'b11, stp, p, d, 1'b0};
    endfunction

    task automatic clock_byte(input logic [7:0] rb, output logic [7:0] got);
        for (int i = 0; i < 8; i++) begin
            sck_drv = 1'b0;
            rxd_drv = rb[i];
            repeat (8) @(negedge clk);
            got[i] = txd;
            sck_drv = 1'b1;
            repeat (8) @(negedge clk);
        end
    endtask

    initial begin
        int w;
        logic [7:0] got;
        cfg(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R11 reset state
        chk("R11 txd idle", {31'h0, txd}, 32'h1);
        chk("R11 tx_busy", {31'h0, tx_busy}, 32'h0);
        chk("R11 rx_full and flags",
            {27'h0, rx_full, rx_frame_err, rx_par_err, rx_overrun, rx_break}, 32'h0);
        chk("R11 sck_oe", {31'h0, sck_oe}, 32'h0);

        // R1 R2 R7: 8N1 loopback, internal clock
        loop = 1'b1;
        expect_rx(8'h55, 5'b0, "R2 8N1 0x55");
        tx_send(8'h55, 1'b0); wait_tx_idle();
        expect_rx(8'hA3, 5'b0, "R2 8N1 0xA3");
        tx_send(8'hA3, 1'b0); wait_tx_idle();
        expect_rx(8'h01, 5'b0, "R2 8N1 0x01");
        tx_send(8'h01, 1'b0); high_width(w); wait_tx_idle();
        chk("R7 bit period internal", w, BIT);
        drain();

        // R2 R3: 7 bits, even parity, two stops
        cfg(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        loop = 1'b1;
        expect_rx(8'h7F, 5'b0, "R3 7E2 0xFF masked");
        tx_send(8'hFF, 1'b0); wait_tx_idle();
        expect_rx(8'h2C, 5'b0, "R3 7E2 0x2C");
        tx_send(8'h2C, 1'b0); wait_tx_idle();
        drain();

        // R3: odd parity with address bit
        cfg(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        loop = 1'b1;
        expect_rx(8'h3A, 5'b10000, "R3 8O1 addr 0x3A");
        tx_send(8'h3A, 1'b1); wait_tx_idle();
        expect_rx(8'h00, 5'b0, "R3 8O1 data 0x00");
        tx_send(8'h00, 1'b0); wait_tx_idle();
        drain();

        // R4 R5: bit-banged 8E1 frames
        cfg(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        loop = 1'b0;
        expect_rx(8'h07, 5'b00100, "R4 parity error");
        rx_bang(frame8e1(8'h07, 1'b0, 1'b1), 11);
        expect_rx(8'h81, 5'b01000, "R4 framing error");
        rx_bang(frame8e1(8'h81, 1'b0, 1'b0), 11);
        expect_rx(8'h00, 5'b01001, "R5 break");
        rx_bang(13'h0, 13);
        expect_rx(8'h42, 5'b0, "R5 recovery after break");
        rx_bang(frame8e1(8'h42, 1'b0, 1'b1), 11);
        drain();

        // R6: overrun keeps first byte
        mon_hold = 1'b1;
        rx_bang(frame8e1(8'h11, 1'b0, 1'b1), 11);
        rx_bang(frame8e1(8'h22, 1'b0, 1'b1), 11);
        expect_rx(8'h11, 5'b00010, "R6 async overrun");
        mon_hold = 1'b0;
        drain();
        repeat (2) @(negedge clk);
        chk("R6 flags cleared by read", {30'h0, rx_full, rx_overrun}, 32'h0);

        // R7: bit-rate clock output
        cfg(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 sck_oe with clock out", {31'h0, sck_oe}, 32'h1);
        while (sck_o) @(negedge clk);
        while (!sck_o) @(negedge clk);
        w = 0;
        while (sck_o) begin w++; @(negedge clk); end
        while (!sck_o) begin w++; @(negedge clk); end
        chk("R7 sck_o period", w, BIT);

        // R8: external x16 clock
        cfg(1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        ext_run = 1'b1;
        loop = 1'b1;
        chk("R8 sck_oe external", {31'h0, sck_oe}, 32'h0);
        expect_rx(8'h01, 5'b0, "R8 external loopback");
        tx_send(8'h01, 1'b0); high_width(w);
        chk("R8 bit period external", w, 128);
        while (tx_busy) @(negedge clk);
        repeat (256) @(negedge clk);
        drain();
        ext_run = 1'b0;
        sck_drv = 1'b1;

        // R1 R9 R10: synchronous internal, async-only options set but ignored
        cfg(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        loop = 1'b1;
        chk("R9 sck_oe internal sync", {31'h0, sck_oe}, 32'h1);
        expect_rx(8'hA5, 5'b0, "R1 R10 sync 8 bits");
        tx_send(8'hA5, 1'b0);
        begin
            logic prev;
            int falls;
            prev = sck_o;
            falls = 0;
            while (tx_busy) begin
                @(negedge clk);
                if (prev && !sck_o) falls++;
                prev = sck_o;
            end
            chk("R9 sck pulses", falls, 8);
        end
        repeat (10) @(negedge clk);
        chk("R9 sck rests high", {31'h0, sck_o}, 32'h1);
        drain();

        // R10: synchronous external, bench is the clock master
        cfg(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        loop = 1'b0;
        chk("R10 sck_oe external sync", {31'h0, sck_oe}, 32'h0);
        expect_rx(8'h3C, 5'b0, "R10 sync external rx");
        tx_send(8'h96, 1'b0);
        clock_byte(8'h3C, got);
        chk("R10 sync external tx", {24'h0, got}, 32'h96);
        repeat (8) @(negedge clk);
        drain();

        // R6 R10: synchronous overrun, idle txd stays high
        mon_hold = 1'b1;
        clock_byte(8'h11, got);
        chk("R10 idle txd in sync", {24'h0, got}, 32'hFF);
        clock_byte(8'h22, got);
        repeat (8) @(negedge clk);
        expect_rx(8'h11, 5'b00010, "R6 R10 sync overrun");
        mon_hold = 1'b0;
        drain();

        chk("scoreboard empty", sbq.size(), 0);
        finish_up();
    end
endmodule